// File: doc/BRIEF.md
# Configurable-frame UART receiver

This block turns an asynchronous serial line into received characters. A 16-bit frame configuration word selects the data width (4 to 9 bits), whether a parity bit follows the data and which sense it has, and the stop-bit length (half, one or two bit periods). The line is resampled in the local clock domain. An external baud generator supplies a 16x oversampling tick, and every bit is sampled at its middle.

Each finished character is stored as a 16-bit extended word in a two-entry receive buffer. The word holds the data bits, a parity-error flag and a framing-error flag. The reader sees the oldest word and a data-valid flag, and takes words out one at a time with a single-cycle pop strobe. If a character finishes while the buffer is full and no pop frees a slot, the character is dropped and a one-cycle overflow pulse is raised. New frames are accepted only while the receive enable is high.

Top module: `uart_frame_rx`

## Requirements
- R1: The data width is frame_cfg[3:0] plus 3. Results below 4 act as 4 and results above 9 act as 9. Data arrives LSB first and lands in rx_word[8:0] with bit i holding data bit i. Bits above the configured width read 0.
- R2: frame_cfg[9] set adds a parity bit after the data, and frame_cfg[8] then selects odd (1) or even (0) parity. A mismatch sets rx_word[14]. With frame_cfg[9] clear, no parity bit is expected and bit 14 reads 0.
- R3: frame_cfg[13:12] selects the stop length: 00 is half a bit, 01 is one bit, 10 and 11 are two bits. A low first stop bit sets rx_word[15].
- R4: With two stop bits, only the first is checked. A low second stop bit sets no flag and starts no extra character.
- R5: rx_word[13:9] always reads 0 while rx_valid is high.
- R6: The buffer holds two words. rx_valid is high exactly while it holds at least one word, and rx_word shows the oldest. A one-cycle rd_pop removes that word by the next cycle. A pop on an empty buffer has no effect.
- R7: A character that completes while the buffer is full, with no pop in that cycle, is discarded, and rx_overflow pulses high for one cycle. The stored words are unchanged.
- R8: If a character completes in the same cycle as a pop on a full buffer, the character is stored and no overflow is raised.
- R9: A line held low for a whole frame yields a word with zero data and rx_word[15] set. No further character follows once the line goes high.
- R10: A low pulse that has ended by the middle of the start bit is ignored.
- R11: While rx_enable is low, a frame on the line produces no word.
- R12: During reset, rx_valid and rx_overflow are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_enable | input | 1 | Accept new frames while high |
| frame_cfg | input | 16 | Frame configuration word (width, parity, stop length) |
| os_tick | input | 1 | 16x oversampling tick, one cycle wide |
| rxd | input | 1 | Serial line, idle high |
| rd_pop | input | 1 | Removes the oldest buffered word |
| rx_word | output | 16 | Oldest buffered word: data, parity error, framing error |
| rx_valid | output | 1 | Buffer holds at least one word |
| rx_overflow | output | 1 | One-cycle pulse when a character is dropped |

## Verification
The writing of a finished character into the buffer and a reader pop can land on the same clock edge. This matters most when the buffer is full, because the pop is what decides whether the character is stored or dropped. The bench first measures, on an empty buffer, how many cycles pass from the start bit until data-valid rises. It then fills the buffer and replays an identical frame, with the pop placed on the cycle of the internal write. The case counts as handled if no overflow pulse appears and the two remaining words come out as the older buffered word followed by the new character.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int unsigned CFG_W    = 16;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned DATA_MIN = 4;
  localparam int unsigned DATA_MAX = 9;
  localparam int unsigned OSR      = 16;
  localparam int unsigned CNT_W    = $clog2(OSR);
  localparam int unsigned BIDX_W   = $clog2(DATA_MAX + 1);

  // configuration field positions
  localparam int unsigned WID_LSB     = 0;
  localparam int unsigned WID_MSB     = 3;
  localparam int unsigned PAR_ODD_BIT = 8;
  localparam int unsigned PAR_EN_BIT  = 9;
  localparam int unsigned STOP_LO     = 12;
  localparam int unsigned STOP_HI     = 13;

  // extended word flag positions
  localparam int unsigned PERR_BIT = 14;
  localparam int unsigned FERR_BIT = 15;

  typedef enum logic [1:0] {
    STOP_HALF = 2'd0,
    STOP_ONE  = 2'd1,
    STOP_TWO  = 2'd2
  } stop_mode_e;

  typedef enum logic [2:0] {
    RX_IDLE   = 3'd0,
    RX_START  = 3'd1,
    RX_DATA   = 3'd2,
    RX_PARITY = 3'd3,
    RX_STOP   = 3'd4,
    RX_TAIL   = 3'd5
  } rx_state_e;

  typedef struct packed {
    logic [BIDX_W-1:0] nbits;
    logic              par_en;
    logic              par_odd;
    stop_mode_e        stop;
  } frame_cfg_t;

  function automatic frame_cfg_t decode_frame_cfg(input logic [CFG_W-1:0] w);
    frame_cfg_t c;
    logic [4:0] width;
    width = {1'b0, w[WID_MSB:WID_LSB]} + 5'd3;
    if (width < 5'(DATA_MIN)) begin
      width = 5'(DATA_MIN);
    end else if (width > 5'(DATA_MAX)) begin
      width = 5'(DATA_MAX);
    end
    c.nbits   = width[BIDX_W-1:0];
    c.par_en  = w[PAR_EN_BIT];
    c.par_odd = w[PAR_ODD_BIT];
    if (w[STOP_HI]) begin
      c.stop = STOP_TWO;
    end else if (w[STOP_LO]) begin
      c.stop = STOP_ONE;
    end else begin
      c.stop = STOP_HALF;
    end
    return c;
  endfunction

endpackage

// File: rtl/uart_rx_rst_sync.sv
module uart_rx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '1;
    end else begin
      sr_q <= sr_d;
    end
  end

  assign q_o = sr_q[STAGES-1];

endmodule

// File: rtl/uart_rx_engine.sv
module uart_rx_engine
  import uart_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic [CFG_W-1:0]  cfg_i,
  output logic              push_o,
  output logic [WORD_W-1:0] word_o
);

  localparam logic [CNT_W-1:0] MID_LAST  = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OSR - 1);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OSR / 2 + OSR / 4 - 1);

  rx_state_e           state_q, state_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [BIDX_W-1:0]   bidx_q, bidx_d;
  logic [DATA_MAX-1:0] data_q, data_d;
  logic                acc_q, acc_d;
  logic                perr_q, perr_d;
  frame_cfg_t          cfg_q, cfg_d;
  logic                push_q, push_d;
  logic [WORD_W-1:0]   word_q, word_d;
  logic [CNT_W-1:0]    stop_last;
  logic [BIDX_W-1:0]   last_bit;

  always_comb begin
    stop_last = (cfg_q.stop == STOP_HALF) ? HALF_LAST : FULL_LAST;
    last_bit  = cfg_q.nbits - 1'b1;
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bidx_d  = bidx_q;
    data_d  = data_q;
    acc_d   = acc_q;
    perr_d  = perr_q;
    cfg_d   = cfg_q;
    push_d  = 1'b0;
    word_d  = word_q;
    case (state_q)
      RX_IDLE: begin
        if (tick_i && en_i && !rxd_i) begin
          state_d = RX_START;
          cnt_d   = '0;
          cfg_d   = decode_frame_cfg(cfg_i);
        end
      end
      RX_START: begin
        if (tick_i) begin
          if (cnt_q == MID_LAST) begin
            if (!rxd_i) begin
              state_d = RX_DATA;
              cnt_d   = '0;
              bidx_d  = '0;
              data_d  = '0;
              acc_d   = 1'b0;
              perr_d  = 1'b0;
            end else begin
              state_d = RX_IDLE;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      RX_DATA: begin
        if (tick_i) begin
          if (cnt_q == FULL_LAST) begin
            data_d[bidx_q] = rxd_i;
            acc_d          = acc_q ^ rxd_i;
            cnt_d          = '0;
            bidx_d         = bidx_q + 1'b1;
            if (bidx_q == last_bit) begin
              state_d = cfg_q.par_en ? RX_PARITY : RX_STOP;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      RX_PARITY: begin
        if (tick_i) begin
          if (cnt_q == FULL_LAST) begin
            perr_d  = acc_q ^ rxd_i ^ cfg_q.par_odd;
            cnt_d   = '0;
            state_d = RX_STOP;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      RX_STOP: begin
        if (tick_i) begin
          if (cnt_q == stop_last) begin
            push_d                   = 1'b1;
            word_d                   = '0;
            word_d[DATA_MAX-1:0]     = data_q;
            word_d[PERR_BIT]         = perr_q;
            word_d[FERR_BIT]         = !rxd_i;
            cnt_d                    = '0;
            state_d = (cfg_q.stop == STOP_TWO) ? RX_TAIL : RX_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      RX_TAIL: begin
        if (tick_i) begin
          if (cnt_q == FULL_LAST) begin
            state_d = RX_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: begin
        state_d = RX_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bidx_q  <= '0;
      data_q  <= '0;
      acc_q   <= 1'b0;
      perr_q  <= 1'b0;
      cfg_q   <= '0;
      push_q  <= 1'b0;
      word_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bidx_q  <= bidx_d;
      data_q  <= data_d;
      acc_q   <= acc_d;
      perr_q  <= perr_d;
      cfg_q   <= cfg_d;
      push_q  <= push_d;
      word_q  <= word_d;
    end
  end

  assign push_o = push_q;
  assign word_o = word_q;

endmodule

// File: rtl/uart_rx_buf.sv
module uart_rx_buf #(
  parameter int unsigned DEPTH  = 2,
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [WIDTH-1:0]  din_i,
  input  logic              pop_i,
  output logic [WIDTH-1:0]  head_o,
  output logic [FILL_W-1:0] fill_o,
  output logic              ovf_o
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0]  mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0]  rd_ptr_q, rd_ptr_d;
  logic [FILL_W-1:0] fill_q, fill_d;
  logic              ovf_q, ovf_d;
  logic              full, empty, do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    full     = (fill_q == FILL_W'(DEPTH));
    empty    = (fill_q == '0);
    do_pop   = pop_i && !empty;
    do_push  = push_i && (!full || do_pop);
    ovf_d    = push_i && full && !do_pop;
    wr_ptr_d = do_push ? ptr_next(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = do_pop ? ptr_next(rd_ptr_q) : rd_ptr_q;
    fill_d   = fill_q + FILL_W'(do_push) - FILL_W'(do_pop);
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[i] <= '0;
      end else if (do_push && (wr_ptr_q == PTR_W'(i))) begin
        mem_q[i] <= din_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      fill_q   <= '0;
      ovf_q    <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      fill_q   <= fill_d;
      ovf_q    <= ovf_d;
    end
  end

  assign head_o = mem_q[rd_ptr_q];
  assign fill_o = fill_q;
  assign ovf_o  = ovf_q;

endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx
  import uart_rx_pkg::*;
#(
  parameter int unsigned BUF_DEPTH   = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_enable,
  input  logic [CFG_W-1:0]  frame_cfg,
  input  logic              os_tick,
  input  logic              rxd,
  input  logic              rd_pop,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid,
  output logic              rx_overflow
);

  localparam int unsigned FILL_W = $clog2(BUF_DEPTH + 1);

  logic              rst_n_int;
  logic              rxd_s;
  logic              eng_push;
  logic [WORD_W-1:0] eng_word;
  logic [FILL_W-1:0] buf_fill;

  uart_rx_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .d_i   (rxd),
    .q_o   (rxd_s)
  );

  uart_rx_engine u_eng (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .en_i   (rx_enable),
    .tick_i (os_tick),
    .rxd_i  (rxd_s),
    .cfg_i  (frame_cfg),
    .push_o (eng_push),
    .word_o (eng_word)
  );

  uart_rx_buf #(
    .DEPTH  (BUF_DEPTH),
    .WIDTH  (WORD_W),
    .FILL_W (FILL_W)
  ) u_buf (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .push_i (eng_push),
    .din_i  (eng_word),
    .pop_i  (rd_pop),
    .head_o (rx_word),
    .fill_o (buf_fill),
    .ovf_o  (rx_overflow)
  );

  assign rx_valid = (buf_fill != '0);

endmodule

// File: rtl/uart_frame_rx_chk.sv
module uart_frame_rx_chk #(
  parameter int unsigned DEPTH  = 2,
  parameter int unsigned FILL_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_pop,
  input logic              rx_valid,
  input logic [15:0]       rx_word,
  input logic              rx_overflow,
  input logic              eng_push,
  input logic [FILL_W-1:0] buf_fill
);

  assert_rsvd_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (rx_word[13:9] == 5'd0));

  assert_valid_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rd_pop) |=> rx_valid);

  assert_fill_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    buf_fill <= FILL_W'(DEPTH));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overflow |-> ($past(eng_push) && ($past(buf_fill) == FILL_W'(DEPTH)) && !$past(rd_pop)));

  assert_pop_frees_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_push && rd_pop) |=> !rx_overflow);

endmodule

bind uart_frame_rx uart_frame_rx_chk #(
  .DEPTH  (BUF_DEPTH),
  .FILL_W (FILL_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_pop      (rd_pop),
  .rx_valid    (rx_valid),
  .rx_word     (rx_word),
  .rx_overflow (rx_overflow),
  .eng_push    (eng_push),
  .buf_fill    (buf_fill)
);

// File: tb/tb_uart_frame_rx.sv
module tb_uart_frame_rx;

  localparam int BIT_CLK = 64; // 16 ticks of 4 clocks

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_enable;
  logic [15:0] frame_cfg;
  logic        os_tick;
  logic        rxd;
  logic        rd_pop;
  logic [15:0] rx_word;
  logic        rx_valid;
  logic        rx_overflow;

  always #10 clk = ~clk;

  uart_frame_rx dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_enable   (rx_enable),
    .frame_cfg   (frame_cfg),
    .os_tick     (os_tick),
    .rxd         (rxd),
    .rd_pop      (rd_pop),
    .rx_word     (rx_word),
    .rx_valid    (rx_valid),
    .rx_overflow (rx_overflow)
  );

  int unsigned cyc = 0;
  logic [1:0]  tcnt = 2'd0;
  always @(posedge clk) begin
    cyc  <= cyc + 1;
    tcnt <= tcnt + 2'd1;
  end
  assign os_tick = (tcnt == 2'd3);

  int          n_chk = 0;
  int          n_fail = 0;
  logic [15:0] q[$];
  int          ovf_seen = 0;
  int          ovf_exp = 0;
  bit          in_frame = 1'b1;
  bit          cmp_on = 1'b0;
  bit          meas = 1'b0;
  int          t0 = 0;
  int          p_lat = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // per-clock comparison against the behavioural model, away from the edge
  always @(posedge clk) begin
    #5;
    if (cmp_on && !in_frame) begin
      check(rx_valid == (q.size() != 0), "R6", "valid vs model",
            32'(rx_valid), 32'(q.size() != 0));
      if (q.size() != 0) begin
        check(rx_word == q[0], "R6", "head word vs model", 32'(rx_word), 32'(q[0]));
      end
    end
    if (rst_n && rx_overflow) ovf_seen++;
  end

  always @(negedge clk) begin
    if (meas && rx_valid && p_lat == 0) p_lat = int'(cyc) - t0;
  end

  function automatic logic [15:0] mkcfg(input logic [3:0] wf, input logic [1:0] par,
                                        input logic [1:0] stp);
    return {2'b00, stp, 2'b00, par, 4'b0000, wf};
  endfunction

  function automatic logic [15:0] exp_word(input logic [8:0] d, input int nb,
                                           input bit perr, input bit ferr);
    logic [8:0] m;
    m = 9'((1 << nb) - 1);
    return {ferr, perr, 5'b0, d & m};
  endfunction

  task automatic model_push(input logic [15:0] w);
    if (q.size() < 2) q.push_back(w);
    else ovf_exp++;
  endtask

  task automatic hold(input logic v, input int n);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic align();
    @(negedge clk);
    while (tcnt != 2'd0) @(negedge clk);
  endtask

  // par: 0 none, 1 even, 2 odd; stp: 0 half, 1 one, 2 two
  task automatic send_frame(input logic [8:0] d, input int nb, input int par, input bit bad,
                            input int stp, input bit s1, input bit s2);
    logic p;
    p = 1'b0;
    hold(1'b0, BIT_CLK);
    for (int i = 0; i < nb; i++) begin
      hold(d[i], BIT_CLK);
      p ^= d[i];
    end
    if (par != 0) begin
      if (par == 2) p = ~p;
      if (bad) p = ~p;
      hold(p, BIT_CLK);
    end
    if (stp == 0) hold(s1, BIT_CLK / 2);
    else hold(s1, BIT_CLK);
    if (stp == 2) hold(s2, BIT_CLK);
    hold(1'b1, 2 * BIT_CLK);
  endtask

  task automatic frame_model(input logic [8:0] d, input int nb, input int par, input bit bad,
                             input int stp, input bit s1, input bit s2,
                             input bit exp_push, input logic [15:0] w);
    in_frame = 1'b1;
    align();
    send_frame(d, nb, par, bad, stp, s1, s2);
    if (exp_push) model_push(w);
    in_frame = 1'b0;
  endtask

  task automatic pop_expect(input logic [15:0] w, input string req);
    @(negedge clk);
    check(rx_valid == 1'b1 && rx_word == w, req, "popped word", 32'(rx_word), 32'(w));
    rd_pop = 1'b1;
    if (q.size() != 0) void'(q.pop_front());
    @(negedge clk);
    rd_pop = 1'b0;
  endtask

  task automatic expect_empty(input string req);
    @(negedge clk);
    check(rx_valid == 1'b0, req, "buffer empty", 32'(rx_valid), 32'd0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R6 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n     = 1'b0;
    rxd       = 1'b1;
    rx_enable = 1'b0;
    rd_pop    = 1'b0;
    frame_cfg = mkcfg(4'd5, 2'b00, 2'b01);
    repeat (5) @(negedge clk);
    check(rx_valid == 1'b0, "R12", "valid in reset", 32'(rx_valid), 32'd0);
    check(rx_overflow == 1'b0, "R12", "overflow in reset", 32'(rx_overflow), 32'd0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    rx_enable = 1'b1;
    in_frame  = 1'b0;
    cmp_on    = 1'b1;

    // R1: widths, LSB first, upper bits zero, clamping
    frame_model(9'h0A5, 8, 0, 0, 1, 1, 1, 1, exp_word(9'h0A5, 8, 0, 0));
    pop_expect(16'h00A5, "R1");
    frame_cfg = mkcfg(4'd2, 2'b00, 2'b01);
    frame_model(9'h1F5, 5, 0, 0, 1, 1, 1, 1, exp_word(9'h015, 5, 0, 0));
    pop_expect(16'h0015, "R1");
    frame_cfg = mkcfg(4'd6, 2'b00, 2'b01);
    frame_model(9'h1A5, 9, 0, 0, 1, 1, 1, 1, exp_word(9'h1A5, 9, 0, 0));
    pop_expect(16'h01A5, "R1");
    frame_cfg = mkcfg(4'd0, 2'b00, 2'b01);
    frame_model(9'h00B, 4, 0, 0, 1, 1, 1, 1, exp_word(9'h00B, 4, 0, 0));
    pop_expect(16'h000B, "R1");
    frame_cfg = mkcfg(4'd15, 2'b00, 2'b01);
    frame_model(9'h10F, 9, 0, 0, 1, 1, 1, 1, exp_word(9'h10F, 9, 0, 0));
    pop_expect(16'h010F, "R1");

    // R2: parity even/odd, good/bad
    frame_cfg = mkcfg(4'd5, 2'b10, 2'b01);
    frame_model(9'h03C, 8, 1, 0, 1, 1, 1, 1, exp_word(9'h03C, 8, 0, 0));
    pop_expect(16'h003C, "R2");
    frame_model(9'h03C, 8, 1, 1, 1, 1, 1, 1, exp_word(9'h03C, 8, 1, 0));
    pop_expect(16'h403C, "R2");
    frame_cfg = mkcfg(4'd5, 2'b11, 2'b01);
    frame_model(9'h03D, 8, 2, 0, 1, 1, 1, 1, exp_word(9'h03D, 8, 0, 0));
    pop_expect(16'h003D, "R2");
    frame_model(9'h07E, 8, 2, 1, 1, 1, 1, 1, exp_word(9'h07E, 8, 1, 0));
    pop_expect(16'h407E, "R2");

    // R3: stop lengths and bad first stop
    frame_cfg = mkcfg(4'd5, 2'b00, 2'b01);
    frame_model(9'h066, 8, 0, 0, 1, 0, 1, 1, exp_word(9'h066, 8, 0, 1));
    pop_expect(16'h8066, "R3");
    frame_cfg = mkcfg(4'd5, 2'b00, 2'b00);
    frame_model(9'h05A, 8, 0, 0, 0, 1, 1, 1, exp_word(9'h05A, 8, 0, 0));
    pop_expect(16'h005A, "R3");

    // R4: bad second stop bit ignored, no extra character
    frame_cfg = mkcfg(4'd5, 2'b00, 2'b11);
    frame_model(9'h0C3, 8, 0, 0, 2, 1, 0, 1, exp_word(9'h0C3, 8, 0, 0));
    pop_expect(16'h00C3, "R4");
    expect_empty("R4");

    // R9: break
    frame_cfg = mkcfg(4'd5, 2'b00, 2'b01);
    in_frame = 1'b1;
    align();
    hold(1'b0, 10 * BIT_CLK);
    hold(1'b1, 3 * BIT_CLK);
    model_push(16'h8000);
    in_frame = 1'b0;
    pop_expect(16'h8000, "R9");
    expect_empty("R9");

    // R10: short start glitch
    in_frame = 1'b1;
    align();
    hold(1'b0, 16);
    hold(1'b1, 4 * BIT_CLK);
    in_frame = 1'b0;
    expect_empty("R10");

    // R11: disabled receiver
    rx_enable = 1'b0;
    frame_model(9'h011, 8, 0, 0, 1, 1, 1, 0, 16'h0);
    expect_empty("R11");
    rx_enable = 1'b1;

    // R6: pop on empty buffer has no effect
    @(negedge clk);
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
    expect_empty("R6");

    // latency measurement on an empty buffer (frame A)
    in_frame = 1'b1;
    align();
    t0   = int'(cyc);
    meas = 1'b1;
    send_frame(9'h0A1, 8, 0, 0, 1, 1, 1);
    meas = 1'b0;
    model_push(16'h00A1);
    in_frame = 1'b0;
    check(p_lat > 1, "R8", "measured latency", 32'(p_lat), 32'd2);

    // frame B fills the buffer
    frame_model(9'h0B2, 8, 0, 0, 1, 1, 1, 1, 16'h00B2);
    @(negedge clk);
    check(rx_valid == 1'b1, "R6", "valid with two words", 32'(rx_valid), 32'd1);

    // R8: frame C completes in the same cycle as a pop on a full buffer
    in_frame = 1'b1;
    align();
    fork
      send_frame(9'h0C4, 8, 0, 0, 1, 1, 1);
      begin
        repeat (p_lat - 1) @(negedge clk);
        rd_pop = 1'b1;
        void'(q.pop_front());
        @(negedge clk);
        rd_pop = 1'b0;
      end
    join
    model_push(16'h00C4);
    in_frame = 1'b0;
    check(ovf_seen == 0, "R8", "no overflow on pop collision", 32'(ovf_seen), 32'd0);

    // R7: frame D dropped while full
    frame_model(9'h0D5, 8, 0, 0, 1, 1, 1, 1, 16'h00D5);
    check(ovf_seen == 1, "R7", "overflow pulses", 32'(ovf_seen), 32'd1);
    check(ovf_exp == 1, "R7", "model overflow count", 32'(ovf_exp), 32'd1);
    pop_expect(16'h00B2, "R7");
    pop_expect(16'h00C4, "R7");
    expect_empty("R7");

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule